// File: doc/BRIEF.md
# Tamper Security Monitor

A small security supervisor that watches ten digital tamper and overflow event lines and tracks three conditions: valid, non-valid and failure. Each event line has an enable bit in a configuration register; an enabled event latches a sticky event flag, raises the security-violation flag and freezes the local time counter. The violation can be signalled as an interrupt.

The whole block is reset by the active-low battery reset `rst_ni`, after which it is non-valid. A system power-on reset arrives as a one-cycle pulse on `sys_por_i`. Leaving failure takes a strict sequence: a system reset (which marks the unit non-valid), zeroing the configuration, clearing the event flags, clearing the violation flag and finally clearing the non-valid flag. Soft and hard lock bits decide whether a system reset is enough or only a battery reset can restore the unit.

Software writes through a single-cycle write port; `wr_sel_i` picks the target: 0 configuration, 1 control, 2 status (write-1-to-clear), 3 interrupt enable.

Top module: `tamper_sec_mon`

## Requirements
- R1: After battery reset, status reads 0x0000_0002 (non-valid flag, bit 1, set), configuration, control and interrupt enable read 0, and `irq_o` is low.
- R2: An event input whose configuration bit is set sets its event flag and the violation flag (status bit 0) at the next clock edge; an event whose configuration bit is clear changes nothing. Event i for i = 0..7 maps to status bit 16+i, event 8 (time overflow) to status bit 2, event 9 (monotonic overflow) to status bit 3.
- R3: Event flags stay set after the event input drops.
- R4: The time counter advances on `tick_i` only while control bit 3 is set and neither the violation nor the non-valid flag is set; its wrap from all-ones to zero acts as event 8.
- R5: In failure without the non-valid flag, writes to status and configuration have no effect.
- R6: A system reset pulse clears control bit 29 (soft lock); with the violation flag set and control bit 16 (failure hard lock) clear it also sets the non-valid flag; with bit 16 set the non-valid flag stays clear.
- R7: Configuration writes are ignored while control bit 29 or bit 30 is set.
- R8: Writing 1 to status bit 0 clears the violation flag only when the non-valid flag is set, configuration is zero, all event flags are clear and control bit 16 is clear.
- R9: Writing 1 to status bit 1 clears the non-valid flag only when the violation flag is already clear.
- R10: Control bits 16, 29 and 30 are set by writing 1; writing 0 leaves them unchanged; only battery reset clears bits 16 and 30.
- R11: `irq_o` is high exactly when the violation flag and interrupt-enable bit 0 are both set.
- R12: Writing 1 to an event flag clears it, unless its enabled event is still asserted in that cycle, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Battery power-on reset, active low, asynchronous |
| sys_por_i | input | 1 | System power-on reset pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 config, 1 control, 2 status, 3 interrupt enable |
| wr_data_i | input | 32 | Write data |
| event_i | input | 10 | Tamper and overflow event lines |
| tick_i | input | 1 | Time counter increment request |
| cfg_o | output | 10 | Event enable register |
| ctrl_o | output | 32 | Control register |
| status_o | output | 32 | Status register |
| irq_en_o | output | 1 | Violation interrupt enable |
| irq_o | output | 1 | Violation interrupt |
| cnt_o | output | CNT_W | Time counter value |

## Verification
The assertions assume `sys_por_i` is a single-cycle pulse and that writes and events are synchronous to `clk_i`; the stimulus drives every input on the falling edge and holds it for whole cycles only. They further assume the battery reset is the only way the hard locks fall, so the bench applies `rst_ni` between scenarios rather than relying on write ordering to leave a locked unit. Event lines are raised only for whole cycles, and held across a system reset only where the set-versus-clear race is the subject.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int NUM_EV  = 10;
  localparam int REG_W   = 32;
  localparam int EV_LO_N = 8;
  localparam int ST_EV0  = 16;
  localparam int ST_TOVF = 2;
  localparam int ST_MOVF = 3;
  localparam int ST_VIOL = 0;
  localparam int ST_NVAL = 1;
  localparam int CT_RUN  = 3;
  localparam int CT_FHL  = 16;
  localparam int CT_SL   = 29;
  localparam int CT_HL   = 30;
  localparam int EV_TOVF = 8;
  localparam int EV_MOVF = 9;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_IEN  = 2'd3
  } wr_sel_e;

  function automatic logic [NUM_EV-1:0] ev_of_word(input logic [REG_W-1:0] w);
    logic [NUM_EV-1:0] r;
    r = '0;
    for (int i = 0; i < EV_LO_N; i++) r[i] = w[ST_EV0+i];
    r[EV_TOVF] = w[ST_TOVF];
    r[EV_MOVF] = w[ST_MOVF];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] word_of_ev(input logic [NUM_EV-1:0] e);
    logic [REG_W-1:0] w;
    w = '0;
    for (int i = 0; i < EV_LO_N; i++) w[ST_EV0+i] = e[i];
    w[ST_TOVF] = e[EV_TOVF];
    w[ST_MOVF] = e[EV_MOVF];
    return w;
  endfunction
endpackage

// File: rtl/tamper_evt_latch.sv
module tamper_evt_latch
  import tamper_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] set_i,
  input  logic [NUM_EV-1:0] clr_i,
  input  logic              frozen_i,
  output logic [NUM_EV-1:0] flag_o
);
  logic [NUM_EV-1:0] flag_q;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R5 / R3: no flag may fall while the unit is in failure-only
  a_r5_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R12: a flag being set by its event cannot be low next cycle
  a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/tamper_time_cnt.sv
module tamper_time_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step   = run_i && tick_i;
  assign wrap_o = step && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R4: counter frozen when not running
  a_r4_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/tamper_state.sv
module tamper_state
  import tamper_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_por_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [NUM_EV-1:0] hit_i,
  input  logic [NUM_EV-1:0] flag_i,
  output logic [NUM_EV-1:0] cfg_o,
  output logic [REG_W-1:0]  ctrl_o,
  output logic              viol_o,
  output logic              nval_o,
  output logic              irq_en_o,
  output logic              fail_only_o
);
  localparam logic [REG_W-1:0] LOCK_MASK =
    (REG_W'(1) << CT_FHL) | (REG_W'(1) << CT_SL) | (REG_W'(1) << CT_HL);
  localparam logic [REG_W-1:0] RUN_MASK = REG_W'(1) << CT_RUN;

  logic [NUM_EV-1:0] cfg_q;
  logic [REG_W-1:0]  ctrl_q, ctrl_d;
  logic              viol_q, nval_q, ien_q;
  logic              wr_cfg, wr_ctrl, wr_stat, wr_ien;
  logic              fail_only, cfg_locked, viol_clr_ok;

  assign wr_cfg  = wr_en_i && (wr_sel_i == SEL_CFG);
  assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign wr_stat = wr_en_i && (wr_sel_i == SEL_STAT);
  assign wr_ien  = wr_en_i && (wr_sel_i == SEL_IEN);

  assign fail_only   = viol_q && !nval_q;
  assign cfg_locked  = ctrl_q[CT_SL] || ctrl_q[CT_HL] || fail_only;
  assign viol_clr_ok = nval_q && (cfg_q == '0) && (flag_i == '0) && !ctrl_q[CT_FHL];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = (ctrl_q & LOCK_MASK) | (wr_data_i & (LOCK_MASK | RUN_MASK));
    if (sys_por_i) ctrl_d[CT_SL] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      ctrl_q <= '0;
      viol_q <= 1'b0;
      nval_q <= 1'b1;
      ien_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_cfg && !cfg_locked) cfg_q <= wr_data_i[NUM_EV-1:0];
      if (wr_ien) ien_q <= wr_data_i[0];
      if (hit_i != '0) viol_q <= 1'b1;
      else if (wr_stat && wr_data_i[ST_VIOL] && viol_clr_ok) viol_q <= 1'b0;
      if (sys_por_i && viol_q && !ctrl_q[CT_FHL]) nval_q <= 1'b1;
      else if (wr_stat && wr_data_i[ST_NVAL] && !viol_q) nval_q <= 1'b0;
    end
  end

  assign cfg_o       = cfg_q;
  assign ctrl_o      = ctrl_q;
  assign viol_o      = viol_q;
  assign nval_o      = nval_q;
  assign irq_en_o    = ien_q;
  assign fail_only_o = fail_only;

  // R8: violation only falls from a clean failure-plus-non-valid state
  a_r8_viol_clear_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(viol_q) |-> ($past(nval_q) && ($past(cfg_q) == '0) &&
                       ($past(flag_i) == '0) && !$past(ctrl_q[CT_FHL])));

  // R9: non-valid only falls after the violation is gone
  a_r9_nval_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nval_q) |-> !$past(viol_q));

  // R5: failure-only persists until a system reset
  a_r5_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_only && !sys_por_i) |=> viol_q);

  // R10: hard locks never fall without battery reset
  a_r10_hard_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CT_HL] |=> ctrl_q[CT_HL]);
  a_r10_fail_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CT_FHL] |=> ctrl_q[CT_FHL]);

  // R7: locked configuration stays put
  a_r7_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CT_SL] || ctrl_q[CT_HL]) |=> $stable(cfg_q));
endmodule

// File: rtl/tamper_sec_mon.sv
module tamper_sec_mon
  import tamper_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_por_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [NUM_EV-1:0] event_i,
  input  logic              tick_i,
  output logic [NUM_EV-1:0] cfg_o,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  status_o,
  output logic              irq_en_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [NUM_EV-1:0] cfg, flags, ev_all, hit, clr;
  logic [REG_W-1:0]  ctrl;
  logic              viol, nval, ien, fail_only, wrap, run;

  assign ev_all = event_i | (NUM_EV'(wrap) << EV_TOVF);
  assign hit    = ev_all & cfg;
  assign clr    = (wr_en_i && (wr_sel_i == SEL_STAT) && !fail_only) ?
                  ev_of_word(wr_data_i) : '0;
  assign run    = ctrl[CT_RUN] && !viol && !nval;

  tamper_state u_state (
    .clk_i, .rst_ni, .sys_por_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .hit_i(hit), .flag_i(flags), .cfg_o(cfg), .ctrl_o(ctrl),
    .viol_o(viol), .nval_o(nval), .irq_en_o(ien), .fail_only_o(fail_only)
  );

  tamper_evt_latch u_latch (
    .clk_i, .rst_ni, .set_i(hit), .clr_i(clr), .frozen_i(fail_only), .flag_o(flags)
  );

  tamper_time_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .tick_i, .cnt_o, .wrap_o(wrap)
  );

  assign cfg_o    = cfg;
  assign ctrl_o   = ctrl;
  assign irq_en_o = ien;
  assign irq_o    = viol && ien;
  assign status_o = word_of_ev(flags) |
                    (REG_W'(viol) << ST_VIOL) | (REG_W'(nval) << ST_NVAL);

  // R2: an enabled event always leaves the violation flag set
  a_r2_hit_viol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> status_o[ST_VIOL]);

  // R11: interrupt never without the violation flag
  a_r11_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o[ST_VIOL] && irq_en_o));
endmodule

// File: tb/tamper_sec_mon_tb_top.sv
`timescale 1ns/1ps
module tamper_sec_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spor = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [9:0]  ev = 10'd0;
  logic        tick = 1'b0;
  logic [9:0]  cfg;
  logic [31:0] ctrl, status;
  logic        ien, irq;
  logic [3:0]  cnt;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tamper_sec_mon #(.CNT_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sys_por_i(spor), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .event_i(ev), .tick_i(tick),
    .cfg_o(cfg), .ctrl_o(ctrl), .status_o(status), .irq_en_o(ien),
    .irq_o(irq), .cnt_o(cnt)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  sel;
    logic [31:0] data;
    logic [9:0]  evt;
    logic        por;
    logic [31:0] exp_st;
    logic [9:0]  exp_cfg;
  } step_t;

  // recovery walk: sel 0 cfg, 1 ctrl, 2 status, 3 irq enable
  localparam step_t TBL [0:14] = '{
    '{1'b1, 2'd0, 32'h0000_0001, 10'h000, 1'b0, 32'h0000_0002, 10'h001}, // R2 enable voltage
    '{1'b1, 2'd2, 32'h0000_0002, 10'h000, 1'b0, 32'h0000_0000, 10'h001}, // R9 to valid
    '{1'b0, 2'd0, 32'h0000_0000, 10'h002, 1'b0, 32'h0000_0000, 10'h001}, // R2 disabled event
    '{1'b0, 2'd0, 32'h0000_0000, 10'h001, 1'b0, 32'h0001_0001, 10'h001}, // R2 enabled event
    '{1'b0, 2'd0, 32'h0000_0000, 10'h000, 1'b0, 32'h0001_0001, 10'h001}, // R3 sticky
    '{1'b1, 2'd2, 32'h0001_0003, 10'h000, 1'b0, 32'h0001_0001, 10'h001}, // R5 status blocked
    '{1'b1, 2'd0, 32'h0000_0000, 10'h000, 1'b0, 32'h0001_0001, 10'h001}, // R5 cfg blocked
    '{1'b0, 2'd0, 32'h0000_0000, 10'h000, 1'b1, 32'h0001_0003, 10'h001}, // R6 sys reset
    '{1'b1, 2'd2, 32'h0000_0001, 10'h000, 1'b0, 32'h0001_0003, 10'h001}, // R8 cfg not zero
    '{1'b1, 2'd0, 32'h0000_0000, 10'h000, 1'b0, 32'h0001_0003, 10'h000}, // disable sources
    '{1'b1, 2'd2, 32'h0000_0001, 10'h000, 1'b0, 32'h0001_0003, 10'h000}, // R8 flags pending
    '{1'b1, 2'd2, 32'h0001_0000, 10'h000, 1'b0, 32'h0000_0003, 10'h000}, // R12 clear flag
    '{1'b1, 2'd2, 32'h0000_0002, 10'h000, 1'b0, 32'h0000_0003, 10'h000}, // R9 too early
    '{1'b1, 2'd2, 32'h0000_0001, 10'h000, 1'b0, 32'h0000_0002, 10'h000}, // R8 clear viol
    '{1'b1, 2'd2, 32'h0000_0002, 10'h000, 1'b0, 32'h0000_0000, 10'h000}  // R9 valid again
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; spor = 1'b0; ev = 10'd0; tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic por();
    @(negedge clk); spor = 1'b1;
    @(negedge clk); spor = 1'b0;
  endtask

  task automatic pulse_ev(input logic [9:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = 10'd0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic batt_reset();
    idle();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 32'h2);
    chk("R1 cfg", {22'd0, cfg}, 32'h0);
    chk("R1 ctrl", ctrl, 32'h0);
    chk("R1 irq", {30'd0, ien, irq}, 32'h0);

    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      wr_en = TBL[i].we; wr_sel = TBL[i].sel; wr_data = TBL[i].data;
      ev = TBL[i].evt; spor = TBL[i].por;
      @(negedge clk);
      idle();
      chk($sformatf("table step %0d status", i), status, TBL[i].exp_st);
      chk($sformatf("table step %0d cfg", i), {22'd0, cfg}, {22'd0, TBL[i].exp_cfg});
    end

    // R11 interrupt
    wr(2'd3, 32'h1);
    wr(2'd0, 32'h1);
    chk("R11 no viol no irq", {31'd0, irq}, 32'h0);
    pulse_ev(10'h001);
    chk("R11 irq high", {31'd0, irq}, 32'h1);
    wr(2'd3, 32'h0);
    chk("R11 irq masked", {31'd0, irq}, 32'h0);
    batt_reset();
    @(negedge clk);
    chk("R1 after battery status", status, 32'h2);
    chk("R1 after battery cfg", {22'd0, cfg}, 32'h0);
    chk("R1 after battery ien", {31'd0, ien}, 32'h0);

    // R10 / R7 / R6 locks
    wr(2'd2, 32'h2);
    wr(2'd1, 32'h2000_0000);
    chk("R10 soft lock set", ctrl, 32'h2000_0000);
    wr(2'd1, 32'h0);
    chk("R10 write 0 ignored", ctrl, 32'h2000_0000);
    wr(2'd0, 32'h3);
    chk("R7 soft lock blocks cfg", {22'd0, cfg}, 32'h0);
    por();
    chk("R6 sys reset drops soft lock", ctrl, 32'h0);
    chk("R6 no viol keeps valid", status, 32'h0);
    wr(2'd0, 32'h3);
    chk("R7 cfg unlocked", {22'd0, cfg}, 32'h3);
    wr(2'd1, 32'h4000_0000);
    por();
    chk("R10 hard lock survives sys reset", ctrl, 32'h4000_0000);
    wr(2'd0, 32'h0);
    chk("R7 hard lock blocks cfg", {22'd0, cfg}, 32'h3);

    // R6 failure hard lock
    batt_reset();
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h0001_0000);
    wr(2'd2, 32'h2);
    pulse_ev(10'h001);
    chk("R2 viol with fail lock", status, 32'h0001_0001);
    por();
    chk("R6 fail lock keeps non-valid clear", status, 32'h0001_0001);
    wr(2'd2, 32'h0001_0001);
    chk("R5 still blocked", status, 32'h0001_0001);

    // R12 set wins over clear
    batt_reset();
    wr(2'd0, 32'h2);
    wr(2'd2, 32'h2);
    @(negedge clk); ev = 10'h002;
    @(negedge clk);
    chk("R2 clock event", status, 32'h0002_0001);
    por();
    chk("R6 into failure plus non-valid", status, 32'h0002_0003);
    wr(2'd2, 32'h0002_0000);
    chk("R12 set wins", status, 32'h0002_0003);
    ev = 10'd0;
    wr(2'd2, 32'h0002_0000);
    chk("R12 clear after drop", status, 32'h0000_0003);

    // R4 counter
    batt_reset();
    wr(2'd1, 32'h8);
    wr(2'd0, 32'h100);
    ticks(2);
    chk("R4 frozen while non-valid", {28'd0, cnt}, 32'h0);
    wr(2'd2, 32'h2);
    ticks(3);
    chk("R4 counts", {28'd0, cnt}, 32'h3);
    ticks(13);
    chk("R4 wrap value", {28'd0, cnt}, 32'h0);
    chk("R4 wrap raises time overflow", status, 32'h0000_0005);
    ticks(2);
    chk("R4 frozen in failure", {28'd0, cnt}, 32'h0);

    finish_run();
  end
endmodule